// File: doc/BRIEF.md
# Dispatch Group Formation Checker

This block sits beside an instruction scheduler and judges one candidate instruction at a time. The candidate arrives with a decoded descriptor: its execution-unit class and five flags. The block reports whether the candidate may join the dispatch group now being built. If it may not, the block says either that the group has to be closed, or that a no-op has to be inserted to break a counter-register hazard. The block keeps a running count of the group's slots and remembers whether the counter register was written inside the group.

The candidate interface is valid/ready. `cand_ready` is the accept verdict and is a combinational function of the descriptor and the current group state; it does not depend on `cand_valid`. An instruction is issued into the group on a clock edge where `cand_valid` and `cand_ready` are both high. While `cand_ready` is low, the scheduler must either keep the descriptor stable or replace it with another candidate. In either case it reacts to `hz_close` by pulsing `grp_advance`, or to `hz_noop` by inserting a no-op and then advancing. A refused candidate with `cand_valid` high changes nothing. `grp_advance` opens a fresh group, and so does the active-low reset `rst_n`.

Top module: `dgf_group_check`

## Requirements
- R1: On every cycle exactly one of `cand_ready`, `hz_close` and `hz_noop` is high. After reset `group_slots` is 0.
- R2: A candidate of class code 0 (pseudo), or one with `cand_marker` set, is always accepted with neither hazard output high. Issuing it leaves the slot count and the counter flag unchanged.
- R3: A candidate with `cand_first_only` or `cand_whole_grp` set gets `hz_close` whenever `group_slots` is not 0.
- R4: A candidate with `cand_cracked` set gets `hz_close` when more than two slots are in use. Otherwise, issuing it adds two to `group_slots`.
- R5: A candidate of class codes 1 to 5 (fixed-point, load/store, floating-point, vector ALU, vector permute) gets `hz_close` when four or more slots are in use.
- R6: A candidate of class code 6 (condition-register unit) gets `hz_close` when two or more slots are in use.
- R7: Issuing a class code 7 (branch) candidate, or a candidate with `cand_whole_grp` set, sets `group_slots` to 5. A branch candidate gets `hz_close` when `group_slots` is 5.
- R8: Once a candidate with `cand_ctr_write` has issued in the group, a later candidate with `cand_ctr_branch` gets `hz_noop`, provided no slot rule already gives it `hz_close`.
- R9: `grp_advance` or reset clears `group_slots` to 0 and also clears the counter-write record. When `grp_advance` and an issue fall in the same cycle, the clear wins.
- R10: Group state changes only on an edge with `cand_valid && cand_ready` or `grp_advance`. Any other issue of a non-ignored candidate adds one slot.
- R11: `group_slots` never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_advance | input | 1 | Close the current group and open an empty one |
| cand_valid | input | 1 | Issue strobe for the presented candidate |
| cand_ready | output | 1 | Candidate may join the group |
| cand_cls | input | 3 | Unit class code (0 pseudo, 1-5 non-branch units, 6 condition register, 7 branch) |
| cand_first_only | input | 1 | Candidate may only take the first slot |
| cand_whole_grp | input | 1 | Candidate occupies a whole group |
| cand_cracked | input | 1 | Candidate splits into two slots |
| cand_ctr_write | input | 1 | Candidate writes the counter register |
| cand_ctr_branch | input | 1 | Candidate branches through the counter register |
| cand_marker | input | 1 | Debug marker, ignored |
| hz_close | output | 1 | Group must close before this candidate |
| hz_noop | output | 1 | A no-op must be inserted before this candidate |
| group_slots | output | 3 | Slots used in the current group |

## Verification
A slot count that is off by one shows up at the ports as a wrong verdict. The verdict goes wrong on the first candidate whose rule threshold lies between the true count and the stored count. A condition-register candidate or a first-slot candidate exposes this almost at once, and a fifth non-branch candidate exposes it at the latest. A lost or stuck counter-write record only appears when a branch through the counter is presented within the same group: it then gives a missing or spurious `hz_noop`. A clear that does not happen on advance leaks into the next group and refuses its first lead-only instruction. The directed scenarios therefore follow every state change with a probe that lands right on the threshold it could disturb, and read `group_slots` one edge after each issue.

// File: rtl/dgf_pkg.sv
package dgf_pkg;

  typedef enum logic [2:0] {
    UC_PSEUDO = 3'd0,
    UC_FIX    = 3'd1,
    UC_LDST   = 3'd2,
    UC_FLT    = 3'd3,
    UC_VALU   = 3'd4,
    UC_VPERM  = 3'd5,
    UC_CREG   = 3'd6,
    UC_BRANCH = 3'd7
  } unit_cls_e;

  typedef struct packed {
    unit_cls_e cls;
    logic      first_only;
    logic      whole_grp;
    logic      cracked;
    logic      ctr_write;
    logic      ctr_branch;
    logic      marker;
  } cand_desc_t;

  typedef enum logic [1:0] {
    VD_ACCEPT = 2'd0,
    VD_CLOSE  = 2'd1,
    VD_NOOP   = 2'd2
  } verdict_e;

  // Decoded view of a candidate used by the rule and state logic.
  typedef struct packed {
    logic ignored;
    logic is_branch;
    logic is_nonbranch;
    logic is_creg;
    logic lead_only;
    logic closes_grp;
    logic two_slot;
    logic sets_ctr;
    logic uses_ctr;
  } cand_attr_t;

endpackage

// File: rtl/dgf_classify.sv
module dgf_classify
  import dgf_pkg::*;
(
  input  cand_desc_t desc,
  output cand_attr_t attr
);

  logic pseudo_cls;
  logic nb_cls;

  always_comb begin
    pseudo_cls = (desc.cls == UC_PSEUDO);
    unique case (desc.cls)
      UC_FIX, UC_LDST, UC_FLT, UC_VALU, UC_VPERM: nb_cls = 1'b1;
      default:                                    nb_cls = 1'b0;
    endcase
  end

  always_comb begin
    attr.ignored      = pseudo_cls | desc.marker;
    attr.is_branch    = (desc.cls == UC_BRANCH);
    attr.is_nonbranch = nb_cls;
    attr.is_creg      = (desc.cls == UC_CREG);
    attr.lead_only    = desc.first_only | desc.whole_grp;
    attr.closes_grp   = (desc.cls == UC_BRANCH) | desc.whole_grp;
    attr.two_slot     = desc.cracked;
    attr.sets_ctr     = desc.ctr_write;
    attr.uses_ctr     = desc.ctr_branch;
  end

endmodule

// File: rtl/dgf_rules.sv
module dgf_rules
  import dgf_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int NONBR_SLOTS = 4,
  parameter int CREG_SLOTS  = 2,
  parameter int CRACK_LIMIT = 2,
  localparam int CNT_W = $clog2(GROUP_SLOTS + 1)
) (
  input  cand_attr_t       attr,
  input  logic [CNT_W-1:0] slots,
  input  logic             ctr_set,
  output verdict_e         verdict
);

  localparam logic [CNT_W-1:0] LIM_NB  = CNT_W'(NONBR_SLOTS);
  localparam logic [CNT_W-1:0] LIM_CR  = CNT_W'(CREG_SLOTS);
  localparam logic [CNT_W-1:0] LIM_CK  = CNT_W'(CRACK_LIMIT);
  localparam logic [CNT_W-1:0] LIM_ALL = CNT_W'(GROUP_SLOTS);

  logic lead_block;
  logic crack_block;
  logic unit_block;
  logic slot_block;

  always_comb begin
    lead_block  = attr.lead_only & (slots != '0);
    crack_block = attr.two_slot & (slots > LIM_CK);
    unit_block  = 1'b0;
    if (attr.is_nonbranch && slots >= LIM_NB) unit_block = 1'b1;
    if (attr.is_creg && slots >= LIM_CR)      unit_block = 1'b1;
    if (attr.is_branch && slots >= LIM_ALL)   unit_block = 1'b1;
    slot_block = lead_block | crack_block | unit_block;
  end

  always_comb begin
    if (attr.ignored)                 verdict = VD_ACCEPT;
    else if (slot_block)              verdict = VD_CLOSE;
    else if (ctr_set & attr.uses_ctr) verdict = VD_NOOP;
    else                              verdict = VD_ACCEPT;
  end

endmodule

// File: rtl/dgf_state.sv
module dgf_state
  import dgf_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  localparam int CNT_W = $clog2(GROUP_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             commit,
  input  cand_attr_t       attr,
  output logic [CNT_W-1:0] slots,
  output logic             ctr_set
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(GROUP_SLOTS);

  logic [CNT_W-1:0] slots_nx;
  logic             ctr_nx;
  logic [CNT_W-1:0] cost;

  always_comb begin
    cost     = attr.two_slot ? CNT_W'(2) : CNT_W'(1);
    slots_nx = slots;
    ctr_nx   = ctr_set;
    if (advance) begin
      slots_nx = '0;
      ctr_nx   = 1'b0;
    end else if (commit && !attr.ignored) begin
      slots_nx = attr.closes_grp ? FULL : slots + cost;
      ctr_nx   = ctr_set | attr.sets_ctr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slots   <= '0;
      ctr_set <= 1'b0;
    end else begin
      slots   <= slots_nx;
      ctr_set <= ctr_nx;
    end
  end

endmodule

// File: rtl/dgf_group_check.sv
module dgf_group_check
  import dgf_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int NONBR_SLOTS = 4,
  parameter int CREG_SLOTS  = 2,
  parameter int CRACK_LIMIT = 2,
  localparam int CNT_W = $clog2(GROUP_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_advance,
  input  logic             cand_valid,
  output logic             cand_ready,
  input  logic [2:0]       cand_cls,
  input  logic             cand_first_only,
  input  logic             cand_whole_grp,
  input  logic             cand_cracked,
  input  logic             cand_ctr_write,
  input  logic             cand_ctr_branch,
  input  logic             cand_marker,
  output logic             hz_close,
  output logic             hz_noop,
  output logic [CNT_W-1:0] group_slots
);

  cand_desc_t       desc;
  cand_attr_t       attr;
  verdict_e         verdict;
  logic [CNT_W-1:0] slots_q;
  logic             ctr_q;
  logic             commit;

  always_comb begin
    desc.cls        = unit_cls_e'(cand_cls);
    desc.first_only = cand_first_only;
    desc.whole_grp  = cand_whole_grp;
    desc.cracked    = cand_cracked;
    desc.ctr_write  = cand_ctr_write;
    desc.ctr_branch = cand_ctr_branch;
    desc.marker     = cand_marker;
  end

  dgf_classify u_cls (
    .desc (desc),
    .attr (attr)
  );

  dgf_rules #(
    .GROUP_SLOTS (GROUP_SLOTS),
    .NONBR_SLOTS (NONBR_SLOTS),
    .CREG_SLOTS  (CREG_SLOTS),
    .CRACK_LIMIT (CRACK_LIMIT)
  ) u_rules (
    .attr    (attr),
    .slots   (slots_q),
    .ctr_set (ctr_q),
    .verdict (verdict)
  );

  assign commit = cand_valid & (verdict == VD_ACCEPT);

  dgf_state #(
    .GROUP_SLOTS (GROUP_SLOTS)
  ) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (grp_advance),
    .commit  (commit),
    .attr    (attr),
    .slots   (slots_q),
    .ctr_set (ctr_q)
  );

  assign cand_ready  = (verdict == VD_ACCEPT);
  assign hz_close    = (verdict == VD_CLOSE);
  assign hz_noop     = (verdict == VD_NOOP);
  assign group_slots = slots_q;

endmodule

// File: rtl/dgf_group_check_sva.sv
module dgf_group_check_sva #(
  parameter int GROUP_SLOTS = 5,
  parameter int NONBR_SLOTS = 4,
  parameter int CREG_SLOTS  = 2,
  parameter int CRACK_LIMIT = 2,
  localparam int CNT_W = $clog2(GROUP_SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             grp_advance,
  input logic             cand_valid,
  input logic             cand_ready,
  input logic [2:0]       cand_cls,
  input logic             cand_first_only,
  input logic             cand_whole_grp,
  input logic             cand_cracked,
  input logic             cand_marker,
  input logic             hz_close,
  input logic             hz_noop,
  input logic [CNT_W-1:0] group_slots
);

  logic ign;
  assign ign = (cand_cls == 3'd0) | cand_marker;

  p_one_verdict_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cand_ready, hz_close, hz_noop}) == 1);

  p_ignored_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ign |-> cand_ready);

  p_ignored_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ign && !grp_advance) |=> $stable(group_slots));

  p_lead_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ign && (cand_first_only || cand_whole_grp) && group_slots != '0) |-> hz_close);

  p_cracked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ign && cand_cracked && group_slots > CNT_W'(CRACK_LIMIT)) |-> hz_close);

  p_nonbranch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ign && cand_cls >= 3'd1 && cand_cls <= 3'd5 && group_slots >= CNT_W'(NONBR_SLOTS))
      |-> hz_close);

  p_creg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ign && cand_cls == 3'd6 && group_slots >= CNT_W'(CREG_SLOTS)) |-> hz_close);

  p_closing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_ready && !ign && !grp_advance &&
     (cand_cls == 3'd7 || cand_whole_grp)) |=> group_slots == CNT_W'(GROUP_SLOTS));

  p_advance_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grp_advance |=> group_slots == '0);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cand_valid && cand_ready) && !grp_advance) |=> $stable(group_slots));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    group_slots <= CNT_W'(GROUP_SLOTS));

endmodule

bind dgf_group_check dgf_group_check_sva #(
  .GROUP_SLOTS (GROUP_SLOTS),
  .NONBR_SLOTS (NONBR_SLOTS),
  .CREG_SLOTS  (CREG_SLOTS),
  .CRACK_LIMIT (CRACK_LIMIT)
) u_sva (
  .clk             (clk),
  .rst_n           (rst_n),
  .grp_advance     (grp_advance),
  .cand_valid      (cand_valid),
  .cand_ready      (cand_ready),
  .cand_cls        (cand_cls),
  .cand_first_only (cand_first_only),
  .cand_whole_grp  (cand_whole_grp),
  .cand_cracked    (cand_cracked),
  .cand_marker     (cand_marker),
  .hz_close        (hz_close),
  .hz_noop         (hz_noop),
  .group_slots     (group_slots)
);

// File: tb/sim_dgf_group_check.sv
`timescale 1ns/1ps
module sim_dgf_group_check;

  localparam int C_PS = 0, C_FIX = 1, C_LDST = 2, C_FLT = 3, C_VALU = 4, C_VPERM = 5,
                 C_CR = 6, C_BR = 7;
  localparam int V_OK = 0, V_CLOSE = 1, V_NOOP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       grp_advance = 1'b0;
  logic       cand_valid = 1'b0;
  logic       cand_ready;
  logic [2:0] cand_cls = 3'd1;
  logic       cand_first_only = 1'b0;
  logic       cand_whole_grp = 1'b0;
  logic       cand_cracked = 1'b0;
  logic       cand_ctr_write = 1'b0;
  logic       cand_ctr_branch = 1'b0;
  logic       cand_marker = 1'b0;
  logic       hz_close;
  logic       hz_noop;
  logic [2:0] group_slots;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  dgf_group_check u0 (
    .clk(clk), .rst_n(rst_n), .grp_advance(grp_advance),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_cls(cand_cls),
    .cand_first_only(cand_first_only), .cand_whole_grp(cand_whole_grp),
    .cand_cracked(cand_cracked), .cand_ctr_write(cand_ctr_write),
    .cand_ctr_branch(cand_ctr_branch), .cand_marker(cand_marker),
    .hz_close(hz_close), .hz_noop(hz_noop), .group_slots(group_slots)
  );

  // Present a candidate descriptor at a falling edge (flags: fo wg ck cw cb mk).
  task automatic present(input int cls, input bit fo, input bit wg, input bit ck,
                         input bit cw, input bit cb, input bit mk);
    @(negedge clk);
    cand_cls = 3'(cls); cand_first_only = fo; cand_whole_grp = wg;
    cand_cracked = ck; cand_ctr_write = cw; cand_ctr_branch = cb; cand_marker = mk;
    #1;
  endtask

  task automatic check_verdict(input int exp, input string req);
    int act;
    n_tests++;
    if ((int'(cand_ready) + int'(hz_close) + int'(hz_noop)) != 1) begin
      n_fail++;
      $display("FAIL R1 (%s): verdict not one-hot ready=%0b close=%0b noop=%0b expected one set",
               req, cand_ready, hz_close, hz_noop);
      return;
    end
    act = cand_ready ? V_OK : (hz_close ? V_CLOSE : V_NOOP);
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: verdict %0d expected %0d (slots=%0d)", req, act, exp, group_slots);
    end
  endtask

  task automatic check_slots(input int exp, input string req);
    n_tests++;
    if (int'(group_slots) != exp) begin
      n_fail++;
      $display("FAIL %s: group_slots %0d expected %0d", req, group_slots, exp);
    end
  endtask

  // Strobe valid through one rising edge; sample 1 ns after it.
  task automatic strobe(input bit adv);
    cand_valid = 1'b1; grp_advance = adv;
    @(posedge clk); #1;
    cand_valid = 1'b0; grp_advance = 1'b0;
  endtask

  task automatic issue(input int cls, input bit fo, input bit wg, input bit ck,
                       input bit cw, input bit cb);
    present(cls, fo, wg, ck, cw, cb, 1'b0);
    strobe(1'b0);
  endtask

  task automatic advance();
    @(negedge clk);
    grp_advance = 1'b1;
    @(posedge clk); #1;
    grp_advance = 1'b0;
  endtask

  task automatic t_reset();
    check_slots(0, "R1 reset");
    present(C_FIX, 0, 0, 0, 0, 0, 0);
    check_verdict(V_OK, "R1 reset accept");
  endtask

  task automatic t_fill();
    issue(C_FIX, 0, 0, 0, 0, 0);  check_slots(1, "R10 +1");
    issue(C_LDST, 0, 0, 0, 0, 0); check_slots(2, "R10 +1");
    issue(C_FLT, 0, 0, 0, 0, 0);  check_slots(3, "R10 +1");
    present(C_VALU, 0, 0, 0, 0, 0, 0); check_verdict(V_OK, "R5 at 3");
    strobe(1'b0); check_slots(4, "R10 +1");
    present(C_VPERM, 0, 0, 0, 0, 0, 0); check_verdict(V_CLOSE, "R5 at 4");
    strobe(1'b0); check_slots(4, "R10 refused hold");
    present(C_BR, 0, 0, 0, 0, 0, 0); check_verdict(V_OK, "R7 branch at 4");
    strobe(1'b0); check_slots(5, "R7 branch closes");
    present(C_BR, 0, 0, 0, 0, 0, 0); check_verdict(V_CLOSE, "R7 second branch");
    strobe(1'b0); check_slots(5, "R11 stays at 5");
    advance(); check_slots(0, "R9 advance");
  endtask

  task automatic t_lead();
    issue(C_FIX, 0, 0, 0, 0, 0);
    present(C_FIX, 1, 0, 0, 0, 0, 0); check_verdict(V_CLOSE, "R3 first-only at 1");
    present(C_CR, 0, 1, 0, 0, 0, 0);  check_verdict(V_CLOSE, "R3 whole at 1");
    advance();
    present(C_CR, 1, 0, 0, 0, 0, 0);  check_verdict(V_OK, "R3 first-only at 0");
    strobe(1'b0); check_slots(1, "R3 first-only issued");
    advance();
    issue(C_FIX, 0, 1, 0, 0, 0); check_slots(5, "R7 whole-group closes");
    advance();
  endtask

  task automatic t_cracked();
    issue(C_LDST, 0, 0, 1, 0, 0); check_slots(2, "R4 cracked +2");
    present(C_FIX, 0, 0, 1, 0, 0, 0); check_verdict(V_OK, "R4 cracked at 2");
    strobe(1'b0); check_slots(4, "R4 cracked +2 again");
    advance();
    issue(C_FIX, 0, 0, 0, 0, 0); issue(C_FIX, 0, 0, 0, 0, 0); issue(C_FIX, 0, 0, 0, 0, 0);
    present(C_FIX, 0, 0, 1, 0, 0, 0); check_verdict(V_CLOSE, "R4 cracked at 3");
    advance();
  endtask

  task automatic t_creg();
    present(C_CR, 0, 0, 0, 0, 0, 0); check_verdict(V_OK, "R6 at 0");
    issue(C_FIX, 0, 0, 0, 0, 0);
    present(C_CR, 0, 0, 0, 0, 0, 0); check_verdict(V_OK, "R6 at 1");
    issue(C_FIX, 0, 0, 0, 0, 0);
    present(C_CR, 0, 0, 0, 0, 0, 0); check_verdict(V_CLOSE, "R6 at 2");
    advance();
  endtask

  task automatic t_ctr();
    present(C_BR, 0, 0, 0, 0, 1, 0); check_verdict(V_OK, "R8 no write yet");
    issue(C_FIX, 0, 0, 0, 1, 0);
    present(C_BR, 0, 0, 0, 0, 1, 0); check_verdict(V_NOOP, "R8 noop");
    present(C_BR, 0, 0, 0, 0, 0, 0); check_verdict(V_OK, "R8 plain branch");
    issue(C_FIX, 0, 0, 0, 0, 0); issue(C_FIX, 0, 0, 0, 0, 0); issue(C_FIX, 0, 0, 0, 0, 0);
    present(C_FIX, 0, 0, 0, 0, 1, 0); check_verdict(V_CLOSE, "R8 close has priority");
    advance();
    present(C_BR, 0, 0, 0, 0, 1, 0); check_verdict(V_OK, "R9 advance clears ctr");
  endtask

  task automatic t_ignored();
    issue(C_FIX, 0, 0, 0, 0, 0); issue(C_FIX, 0, 0, 0, 0, 0);
    issue(C_FIX, 0, 0, 0, 0, 0); issue(C_FIX, 0, 0, 0, 0, 0);
    present(C_PS, 1, 1, 1, 1, 0, 0); check_verdict(V_OK, "R2 pseudo at 4");
    strobe(1'b0); check_slots(4, "R2 pseudo no slot");
    present(C_FIX, 0, 0, 0, 1, 0, 1); check_verdict(V_OK, "R2 marker at 4");
    strobe(1'b0); check_slots(4, "R2 marker no slot");
    present(C_BR, 0, 0, 0, 0, 1, 0); check_verdict(V_OK, "R2 no ctr record");
    advance();
  endtask

  task automatic t_hold();
    present(C_FIX, 0, 0, 0, 0, 0, 0);
    @(posedge clk); #1; check_slots(0, "R10 no valid no change");
    issue(C_FIX, 0, 0, 0, 0, 0);
    present(C_FIX, 0, 0, 1, 0, 0, 0);
    strobe(1'b1); check_slots(0, "R9 advance wins over issue");
    issue(C_FIX, 0, 0, 0, 1, 0); issue(C_FIX, 0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1; rst_n = 1'b1;
    check_slots(0, "R9 reset clears");
    present(C_BR, 0, 0, 0, 0, 1, 0); check_verdict(V_OK, "R9 reset clears ctr");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fill();
    t_lead();
    t_cracked();
    t_creg();
    t_ctr();
    t_ignored();
    t_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule